// File: doc/BRIEF.md
# Two-wire byte memory slave controller

This block is the bus-facing controller of a small serial memory. It watches a two-wire bus (a clock line and an open-drain data line), both sampled by a faster system clock. It recognises start and stop conditions and runs the byte-level protocol for a 128-byte array. The array and its nonvolatile commit timing sit outside the block. The block hands each received byte to them as a one-cycle write request with an address. It reads bytes through a combinational read port that follows its address output.

A transfer has no device-select byte. The first byte after a start carries the 7-bit word address, most significant bit first, followed by a direction bit. In a write, each following byte is acknowledged and requested. The address then steps inside a 4-byte page. In a read, bytes are shifted out most significant bit first for as long as the master acknowledges. The address steps across the whole array. While the external busy input is high, the block behaves as if the bus were silent.

Top module: `twowire_mem_slave`

## Requirements
- R1: After reset the data pull-low is off and no write is requested. Until a start (data falling while the clock is high) has been seen, clocked bits get no acknowledge.
- R2: A stop (data rising while the clock is high) releases the data line and returns the block to idle. Bits clocked after a stop get no acknowledge until the next start.
- R3: The first byte after a start is 7 address bits, MSB first, then a direction bit (1 = read, 0 = write). The block acknowledges it by pulling data low for the whole ninth clock.
- R4: In a write, every data byte is acknowledged. With the start of that acknowledge, a one-cycle write request carries the current address and the received byte.
- R5: After each written byte, address bits [1:0] increment and wrap within the page, while bits [6:2] stay fixed. A fifth byte therefore overwrites the first byte's location.
- R6: In a read, the byte at the current address is driven MSB first, one bit per clock. The data line is released for the ninth clock.
- R7: When the master acknowledges a read byte, the next byte comes from the address plus one, wrapping from 127 to 0.
- R8: When the master does not acknowledge a read byte, the block stops driving. It stays released for any further clocks until a new start.
- R9: While busy is high, the pull-low is released by the next clock edge. Starts, address bytes and data bytes are ignored: no acknowledge and no write request.
- R10: A start in the middle of a transfer restarts address reception (repeated start).
- R11: The pull-low only turns on in response to a falling clock edge on the bus.
- R12: Each bus line passes through a two-flop synchronizer. The pull-low changes on the third system clock edge after the bus clock falls at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired value) |
| busy_i | input | 1 | Memory commit in progress; bus is ignored |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| wr_req_o | output | 1 | One-cycle write request |
| wr_addr_o | output | 7 | Write address |
| wr_data_o | output | 8 | Write data |
| rd_addr_o | output | 7 | Current address for the read port |
| rd_data_i | input | 8 | Byte at rd_addr_o, combinational |

## Verification
A change on the bus clock pin shows as an edge inside the block two system clocks later. The pull-low responds on the third edge. The bench checks this exact count once around an address acknowledge, and reads every other bus result in the middle of the clock-high phase, long after it has settled. A write request appears in the same cycle as the acknowledge pull-low and is compared against an expected queue on every clock. A busy assertion must clear the pull-low one clock later, and the bench samples it exactly then.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_RLOAD
  } tw_state_e;
endpackage

// File: rtl/tw_bus_sampler.sv
module tw_bus_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_s;

  // idle bus is high: reset to ones so no edge appears at reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/tw_addr_ctr.sv
module tw_addr_ctr #(
  parameter int AW        = 7,
  parameter int PAGE_BITS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_seq_i,
  input  logic          inc_page_i,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         addr_o <= '0;
    else if (load_i)     addr_o <= load_val_i;
    else if (inc_seq_i)  addr_o <= addr_o + 1'b1;
    else if (inc_page_i) addr_o <= {addr_o[AW-1:PAGE_BITS], addr_o[PAGE_BITS-1:0] + 1'b1};
  end

  // R7: sequential step over the full range
  a_r7_seq_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_seq_i && !load_i) |=> (addr_o == AW'($past(addr_o) + 1'b1)));

  // R5: page step keeps the page bits
  a_r5_page_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_page_i && !load_i && !inc_seq_i) |=>
      (addr_o[AW-1:PAGE_BITS] == $past(addr_o[AW-1:PAGE_BITS])));
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave
  import tw_pkg::*;
#(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int PAGE_BITS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          busy_i,
  output logic          sda_pull_o,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic act, addr_load, inc_seq, inc_page;
  tw_state_e st;
  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] rx_sh, tx_sh;
  logic rw_q, ack_on, pull_q;

  tw_bus_sampler #(.STAGES(SYNC_STAGES)) u_smp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  assign act       = !busy_i && !start_c && !stop_c;
  assign addr_load = act && (st == ST_AACK) && scl_fall && !ack_on;
  assign inc_page  = act && (st == ST_WACK) && scl_fall && !ack_on;
  assign inc_seq   = act && (st == ST_RACK) && scl_fall;

  tw_addr_ctr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (addr_load),
    .load_val_i (rx_sh[DW-1 -: AW]),
    .inc_seq_i  (inc_seq),
    .inc_page_i (inc_page),
    .addr_o     (rd_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rw_q      <= 1'b0;
      ack_on    <= 1'b0;
      pull_q    <= 1'b0;
      wr_req_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_req_o <= 1'b0;
      if (busy_i) begin
        st     <= ST_IDLE;
        pull_q <= 1'b0;
        ack_on <= 1'b0;
      end else if (start_c) begin
        st      <= ST_ADDR;
        bit_cnt <= '0;
        pull_q  <= 1'b0;
        ack_on  <= 1'b0;
      end else if (stop_c) begin
        st     <= ST_IDLE;
        pull_q <= 1'b0;
        ack_on <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_WDATA: if (scl_rise) begin
            rx_sh   <= {rx_sh[DW-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              bit_cnt <= '0;
              st      <= (st == ST_ADDR) ? ST_AACK : ST_WACK;
            end
          end
          ST_AACK: if (scl_fall) begin
            if (!ack_on) begin
              ack_on <= 1'b1;
              pull_q <= 1'b1;
              rw_q   <= rx_sh[0];
            end else begin
              ack_on  <= 1'b0;
              bit_cnt <= '0;
              if (rw_q) begin
                st     <= ST_RDATA;
                tx_sh  <= rd_data_i;
                pull_q <= ~rd_data_i[DW-1];
              end else begin
                st     <= ST_WDATA;
                pull_q <= 1'b0;
              end
            end
          end
          ST_WACK: if (scl_fall) begin
            if (!ack_on) begin
              ack_on    <= 1'b1;
              pull_q    <= 1'b1;
              wr_req_o  <= 1'b1;
              wr_addr_o <= rd_addr_o;
              wr_data_o <= rx_sh;
            end else begin
              ack_on <= 1'b0;
              pull_q <= 1'b0;
              st     <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == LAST_BIT) begin
                bit_cnt <= '0;
                st      <= ST_RACK;
              end
            end else if (scl_fall) begin
              pull_q <= ~tx_sh[LAST_BIT - bit_cnt];
            end
          end
          ST_RACK: begin
            if (scl_fall) pull_q <= 1'b0;
            else if (scl_rise) st <= sda_s ? ST_IDLE : ST_RLOAD;
          end
          ST_RLOAD: if (scl_fall) begin
            tx_sh   <= rd_data_i;
            pull_q  <= ~rd_data_i[DW-1];
            bit_cnt <= '0;
            st      <= ST_RDATA;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;

  a_r9_busy_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !sda_pull_o);

  a_r2_stop_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_c |=> !sda_pull_o);

  a_r11_pull_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> $past(scl_fall));

  a_r4_req_with_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> sda_pull_o);

  a_r8_nack_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && st == ST_RACK && scl_rise && sda_s) |=> (st == ST_IDLE && !sda_pull_o));
endmodule

// File: tb/sim_twowire_mem_slave.sv
module sim_twowire_mem_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_pull, wr_req;
  logic [6:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [7:0] mem [0:127];
  logic [6:0] exp_wa [$];
  logic [7:0] exp_wd [$];
  int n_chk = 0, n_err = 0;
  wire sda_line = sda_m & ~sda_pull;

  always #5 clk = ~clk;

  twowire_mem_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .busy_i(busy),
    .sda_pull_o(sda_pull), .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  assign rd_data = mem[rd_addr];

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 3 + 7);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model and write-request compare on every clock
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= init_val(i);
    end else if (wr_req) begin
      if (exp_wa.size() == 0) chk(1'b0, "R4 unexpected write", wr_addr, 0);
      else begin
        chk(wr_addr == exp_wa[0], "R4/R5 write address", wr_addr, exp_wa[0]);
        chk(wr_data == exp_wd[0], "R4 write data", wr_data, exp_wd[0]);
        void'(exp_wa.pop_front());
        void'(exp_wd.pop_front());
      end
      mem[wr_addr] <= wr_data;
    end
  end

  task automatic wq(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(Q);
  endtask

  task automatic clk_bit(input bit b, output bit s);
    sda_m = b; wq(Q); scl_m = 1; wq(Q/2); s = sda_line; wq(Q/2); scl_m = 0;
  endtask

  // mode 0 plain, 1 latency check on ack, 2 busy raised during ack
  task automatic send_byte(input logic [7:0] b, input int mode, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    sda_m = 1;
    if (mode == 1) begin
      wq(2); chk(sda_pull == 1'b0, "R12 pull before third edge", sda_pull, 0);
      wq(1); chk(sda_pull == 1'b1, "R12 pull on third edge", sda_pull, 1);
      wq(Q-3);
    end else if (mode == 2) begin
      wq(3); busy = 1;
      wq(1); chk(sda_pull == 1'b0, "R9 busy releases pull", sda_pull, 0);
      wq(Q-4);
    end else wq(Q);
    scl_m = 1; wq(Q/2); acked = !sda_line; wq(Q/2); scl_m = 0;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
    clk_bit(!ack, s);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    wq(150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    logic [7:0] pg [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    logic [6:0] pa [5] = '{7'h1E, 7'h1F, 7'h1C, 7'h1D, 7'h1E};

    wq(3);
    chk(sda_pull == 1'b0, "R1 reset pull", sda_pull, 0);
    chk(wr_req == 1'b0, "R1 reset write request", wr_req, 0);
    rst_n = 1; wq(4);

    // R1: no start seen
    scl_m = 0; wq(Q);
    send_byte({7'h20, 1'b0}, 0, ack);
    chk(!ack, "R1 no ack before start", ack, 0);

    // R3, R4, R12: byte write
    bus_start();
    send_byte({7'h10, 1'b0}, 1, ack);
    chk(ack, "R3 address ack", ack, 1);
    exp_wa.push_back(7'h10); exp_wd.push_back(8'hA5);
    send_byte(8'hA5, 0, ack);
    chk(ack, "R4 data ack", ack, 1);
    bus_stop(); wq(2);
    chk(exp_wa.size() == 0, "R4 write issued", exp_wa.size(), 0);

    // R5: five bytes into the page at 0x1C
    bus_start();
    send_byte({7'h1E, 1'b0}, 0, ack);
    chk(ack, "R3 page address ack", ack, 1);
    for (int i = 0; i < 5; i++) begin
      exp_wa.push_back(pa[i]); exp_wd.push_back(pg[i]);
      send_byte(pg[i], 0, ack);
      chk(ack, "R5 page byte ack", ack, 1);
    end
    bus_stop(); wq(2);

    // R6, R7, R8: sequential read then nack
    bus_start();
    send_byte({7'h10, 1'b1}, 0, ack);
    chk(ack, "R3 read address ack", ack, 1);
    recv_byte(1'b1, d); chk(d == 8'hA5, "R6 read byte", d, 8'hA5);
    recv_byte(1'b1, d); chk(d == init_val(8'h11), "R7 next address", d, init_val(8'h11));
    recv_byte(1'b0, d); chk(d == init_val(8'h12), "R7 third byte", d, init_val(8'h12));
    recv_byte(1'b1, d); chk(d == 8'hFF, "R8 released after nack", d, 8'hFF);
    bus_stop();

    // R5: page readback
    bus_start();
    send_byte({7'h1C, 1'b1}, 0, ack);
    recv_byte(1'b1, d); chk(d == 8'h33, "R5 page 1C", d, 8'h33);
    recv_byte(1'b1, d); chk(d == 8'h44, "R5 page 1D", d, 8'h44);
    recv_byte(1'b1, d); chk(d == 8'h55, "R5 page 1E overwrite", d, 8'h55);
    recv_byte(1'b0, d); chk(d == 8'h22, "R5 page 1F", d, 8'h22);
    bus_stop();

    // R7: wrap 127 -> 0
    bus_start();
    send_byte({7'h7F, 1'b1}, 0, ack);
    recv_byte(1'b1, d); chk(d == init_val(127), "R7 byte 127", d, init_val(127));
    recv_byte(1'b0, d); chk(d == init_val(0), "R7 wrap to 0", d, init_val(0));
    bus_stop();

    // R10: repeated start
    bus_start();
    send_byte({7'h20, 1'b0}, 0, ack);
    chk(ack, "R10 first address ack", ack, 1);
    bus_start();
    send_byte({7'h1E, 1'b1}, 0, ack);
    chk(ack, "R10 second address ack", ack, 1);
    recv_byte(1'b0, d); chk(d == 8'h55, "R10 read after restart", d, 8'h55);
    bus_stop();

    // R2: stop mid-byte
    bus_start();
    send_byte({7'h30, 1'b0}, 0, ack);
    for (int i = 0; i < 3; i++) clk_bit(1'b1, ack);
    bus_stop();
    scl_m = 0; wq(Q);
    send_byte({7'h30, 1'b0}, 0, ack);
    chk(!ack, "R2 no ack after stop", ack, 0);

    // R9: busy
    bus_start();
    send_byte({7'h40, 1'b0}, 2, ack);
    chk(!ack, "R9 ack withdrawn", ack, 0);
    bus_stop();
    bus_start();
    send_byte({7'h40, 1'b0}, 0, ack);
    chk(!ack, "R9 start ignored while busy", ack, 0);
    busy = 0;
    send_byte(8'h77, 0, ack);
    chk(!ack, "R9 no ack without new start", ack, 0);
    bus_stop();
    bus_start();
    send_byte({7'h40, 1'b1}, 0, ack);
    recv_byte(1'b0, d); chk(d == init_val(8'h40), "R9 no write happened", d, init_val(8'h40));
    bus_stop();

    wq(10);
    chk(exp_wa.size() == 0, "R4 all writes seen", exp_wa.size(), 0);
    summary();
    $finish;
  end
endmodule